// File: doc/BRIEF.md
# Transmit Dominant Timeout Monitor

This block sits in the transmit path between a bus protocol controller and the enable of a differential line driver. It watches the transmit line for a dominant (low) level. A falling edge on the synchronized line starts a cycle counter. If the line is still dominant when the counter reaches a programmable limit, the block turns the driver off. The gated transmit output then goes recessive (high), so a stuck controller cannot block the shared bus. The same event also raises a sticky fault flag.

The driver comes back only on the next recessive edge of the transmit line. Neither a timer nor a mode change re-enables it. The receive path is never gated: the sampled bus level keeps reaching the receive output while the fault is active, so the node can still follow traffic from other nodes.

Monitoring runs only while the mode input reports the driver as active. The limit is given in clock cycles. Set it to the shortest allowed dominant window, which is 1.2 ms at the target clock. With that window, eleven back-to-back dominant bits still fit at rates down to roughly 9.2 kbit/s.

Top module: `txdom_guard`

## Requirements
- R1: After reset, `faultFlag` is 0, `txOut` and `rxOut` are 1 (recessive), and `drvEn` equals `drvActive`.
- R2: While `drvEn` is 1, `txOut` equals `txIn` delayed by two clock edges. While `drvEn` is 0, `txOut` is 1 whatever `txIn` does.
- R3: In active mode, `txIn` may be sampled low on N consecutive edges following a high sample, with N >= TIMEOUT_CYCLES. In that case `drvEn` goes to 0 and `faultFlag` goes to 1 right after edge TIMEOUT_CYCLES+2, counting the first low sample as edge 1.
- R4: A dominant run of N < TIMEOUT_CYCLES samples ends with a rising edge. It clears the measurement and never disables the driver or sets the fault.
- R5: Once tripped, `drvEn` stays 0 for as long as `txIn` stays low, however long that is (the counter saturates and does not wrap). It returns to 1 right after edge N+3, where N is the last low sample, that is, on the synchronized low-to-high transition.
- R6: `faultFlag` is sticky. It stays 1 after the driver is re-enabled and clears only on an edge where `faultClr` is 1. If a trip and `faultClr` fall on the same edge, the flag ends up 1.
- R7: While `drvActive` is 0, `drvEn` is 0, no measurement runs, and no fault is raised, whatever the length of a dominant run.
- R8: A dominant level that is already present when active mode is entered does not start a measurement. Only a fresh falling edge does.
- R9: `rxOut` equals `busIn` delayed by two clock edges at all times, including while the driver is disabled by a timeout.
- R10: If active mode is dropped while a measurement runs, the measurement is abandoned. A later dominant run is timed from its own falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| drvActive | input | 1 | Mode: 1 when the line driver is in its active mode |
| txIn | input | 1 | Raw transmit line from the controller, 0 = dominant |
| faultClr | input | 1 | Clears the sticky fault flag on a clock edge |
| busIn | input | 1 | Bus level from the line receiver |
| drvEn | output | 1 | Line driver enable |
| txOut | output | 1 | Transmit line to the driver, forced to 1 while disabled |
| rxOut | output | 1 | Synchronized bus level to the controller |
| faultFlag | output | 1 | Sticky timeout fault |

## Verification
The assertions check, on every cycle, the properties that involve no timing:
- the two-edge receive delay;
- the stickiness of the fault flag and the fact that it appears only together with a disabled driver;
- the counter staying at or below the limit and being cleared outside active mode;
- re-enabling only after a synchronized recessive sample.

Only the bench scenarios can show the exact trip edge for each run length on both sides of the limit. The same holds for three further cases: the set-wins collision with `faultClr`, the refusal to time a dominant level held across the mode change, and the restarted measurement after active mode is dropped in mid-run.

// File: rtl/txdom_pkg.sv
`timescale 1ns/1ps
package txdom_pkg;

  // Monitor state: waiting for a falling edge, timing a dominant run,
  // or holding the driver off after a timeout.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TIMING  = 2'd1,
    ST_TRIPPED = 2'd2
  } monState_t;

  // Strobes from control to the run counter in the datapath.
  typedef struct packed {
    logic runClear;    // force counter to zero
    logic runStart;    // first dominant sample: counter to one
    logic runAdvance;  // one more dominant sample, saturating
  } cntCtl_t;

endpackage

// File: rtl/txdom_sync.sv
`timescale 1ns/1ps
module txdom_sync #(
  parameter int  STAGES    = 2,
  parameter bit  RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= dIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chain <= {STAGES{RESET_VAL}};
        end else begin
          chain <= {chain[STAGES-2:0], dIn};
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/txdom_datapath.sv
`timescale 1ns/1ps
module txdom_datapath
  import txdom_pkg::*;
#(
  parameter int LIMIT       = 300000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txIn,
  input  logic             busIn,
  input  logic             drvEn,
  input  cntCtl_t          ctl,
  output logic             txSync,
  output logic             txFall,
  output logic             txRise,
  output logic             nearLimit,
  output logic [CNT_W-1:0] runCount,
  output logic             txOut,
  output logic             rxOut
);

  localparam logic [CNT_W-1:0] LIMIT_V     = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] LIMIT_M1_V  = CNT_W'(LIMIT - 1);
  localparam logic [CNT_W-1:0] ONE_V       = CNT_W'(1);

  logic txPrev;
  logic busSync;

  // Transmit line into the clock domain; recessive while in reset.
  txdom_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uTxSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (txIn),
    .dOut (txSync)
  );

  // Bus level back toward the controller, same latency as transmit.
  txdom_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uBusSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (busIn),
    .dOut (busSync)
  );

  // Previous synchronized sample for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txPrev <= 1'b1;
    else       txPrev <= txSync;
  end

  assign txFall = txPrev & ~txSync;
  assign txRise = ~txPrev & txSync;

  // Dominant run counter: counts low samples, saturates at the limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (ctl.runClear) begin
      runCount <= '0;
    end else if (ctl.runStart) begin
      runCount <= ONE_V;
    end else if (ctl.runAdvance && (runCount != LIMIT_V)) begin
      runCount <= runCount + ONE_V;
    end
  end

  assign nearLimit = (runCount == LIMIT_M1_V);

  // Gated transmit: recessive whenever the driver is off.
  assign txOut = drvEn ? txSync : 1'b1;

  // Receive path is never gated.
  assign rxOut = busSync;

endmodule

// File: rtl/txdom_ctrl.sv
`timescale 1ns/1ps
module txdom_ctrl
  import txdom_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    drvActive,
  input  logic    faultClr,
  input  logic    txFall,
  input  logic    txRise,
  input  logic    nearLimit,
  output cntCtl_t ctl,
  output logic    drvEn,
  output logic    faultFlag
);

  monState_t state;
  monState_t nextState;
  logic      tripNow;

  always_comb begin
    nextState = state;
    ctl       = '0;
    tripNow   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (drvActive && txFall) begin
          nextState    = ST_TIMING;
          ctl.runStart = 1'b1;
        end else begin
          ctl.runClear = 1'b1;
        end
      end
      ST_TIMING: begin
        if (!drvActive || txRise) begin
          // Mode left or run ended early: abandon without fault.
          nextState    = ST_IDLE;
          ctl.runClear = 1'b1;
        end else if (nearLimit) begin
          nextState      = ST_TRIPPED;
          ctl.runAdvance = 1'b1;
          tripNow        = 1'b1;
        end else begin
          ctl.runAdvance = 1'b1;
        end
      end
      ST_TRIPPED: begin
        if (txRise) begin
          // Only a recessive edge releases the driver.
          nextState    = ST_IDLE;
          ctl.runClear = 1'b1;
        end else if (!drvActive) begin
          ctl.runClear = 1'b1;
        end else begin
          ctl.runAdvance = 1'b1;
        end
      end
      default: begin
        nextState    = ST_IDLE;
        ctl.runClear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // Sticky fault: a trip wins over a clear on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         faultFlag <= 1'b0;
    else if (tripNow)  faultFlag <= 1'b1;
    else if (faultClr) faultFlag <= 1'b0;
  end

  assign drvEn = drvActive && (state != ST_TRIPPED);

endmodule

// File: rtl/txdom_guard.sv
`timescale 1ns/1ps
module txdom_guard
  import txdom_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 300000,
  parameter int SYNC_STAGES    = 2,
  localparam int CNT_W         = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic drvActive,
  input  logic txIn,
  input  logic faultClr,
  input  logic busIn,
  output logic drvEn,
  output logic txOut,
  output logic rxOut,
  output logic faultFlag
);

  cntCtl_t          ctl;
  logic             txSync;
  logic             txFall;
  logic             txRise;
  logic             nearLimit;
  logic [CNT_W-1:0] runCount;

  txdom_datapath #(.LIMIT(TIMEOUT_CYCLES), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .txIn      (txIn),
    .busIn     (busIn),
    .drvEn     (drvEn),
    .ctl       (ctl),
    .txSync    (txSync),
    .txFall    (txFall),
    .txRise    (txRise),
    .nearLimit (nearLimit),
    .runCount  (runCount),
    .txOut     (txOut),
    .rxOut     (rxOut)
  );

  txdom_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .drvActive (drvActive),
    .faultClr  (faultClr),
    .txFall    (txFall),
    .txRise    (txRise),
    .nearLimit (nearLimit),
    .ctl       (ctl),
    .drvEn     (drvEn),
    .faultFlag (faultFlag)
  );

endmodule

// File: rtl/txdom_guard_checker.sv
`timescale 1ns/1ps
module txdom_guard_checker #(
  parameter int LIMIT       = 300000,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(LIMIT + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             drvActive,
  input logic             faultClr,
  input logic             busIn,
  input logic             drvEn,
  input logic             rxOut,
  input logic             faultFlag,
  input logic             txSync,
  input logic [CNT_W-1:0] runCount
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  // Own delay line for the receive path, reset to recessive.
  logic [SYNC_STAGES-1:0] busHist;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busHist <= {SYNC_STAGES{1'b1}};
    else if (SYNC_STAGES == 1) busHist <= SYNC_STAGES'(busIn);
    else busHist <= {busHist[SYNC_STAGES-2:0], busIn} >> 0;
  end

  // R9: receive output trails the bus by the synchronizer depth.
  a_r9_rx_tracks_bus: assert property (@(posedge clk) disable iff (!rstN)
    rxOut == busHist[SYNC_STAGES-1]);

  // R6: fault stays set unless cleared.
  a_r6_fault_holds: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag && !faultClr |=> faultFlag);

  // R3: a new fault always comes with the driver switched off.
  a_r3_fault_with_trip: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultFlag) |-> !drvEn && $past(drvActive));

  // R3: driver falls in active mode only when the run reaches the limit.
  a_r3_trip_at_limit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drvEn) && drvActive && $past(drvActive) |-> runCount == LIMIT_V);

  // R5: counter saturates and never passes the limit.
  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    runCount <= LIMIT_V);

  // R5: re-enable in active mode follows a recessive sample.
  a_r5_reenable_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEn) && $past(drvActive) |-> $past(txSync));

  // R7: outside active mode the counter is held cleared.
  a_r7_inactive_clears: assert property (@(posedge clk) disable iff (!rstN)
    !drvActive |=> runCount == '0);

endmodule

bind txdom_guard txdom_guard_checker #(
  .LIMIT       (TIMEOUT_CYCLES),
  .SYNC_STAGES (SYNC_STAGES)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .drvActive (drvActive),
  .faultClr  (faultClr),
  .busIn     (busIn),
  .drvEn     (drvEn),
  .rxOut     (rxOut),
  .faultFlag (faultFlag),
  .txSync    (txSync),
  .runCount  (runCount)
);

// File: tb/txdom_guard_test.sv
`timescale 1ns/1ps
module txdom_guard_test;

  localparam int LIM = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic drvActive = 1'b1;
  logic txIn = 1'b1;
  logic faultClr = 1'b0;
  logic busIn = 1'b1;
  logic drvEn, txOut, rxOut, faultFlag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  txdom_guard #(.TIMEOUT_CYCLES(LIM), .SYNC_STAGES(2)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .drvActive (drvActive),
    .txIn      (txIn),
    .faultClr  (faultClr),
    .busIn     (busIn),
    .drvEn     (drvEn),
    .txOut     (txOut),
    .rxOut     (rxOut),
    .faultFlag (faultFlag)
  );

  always #2 clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic nextBus();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    busIn = lfsr[0];
  endtask

  // Quiet line for a few edges, then clear any fault and confirm it.
  task automatic settle();
    txIn = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    faultClr = 1'b1;
    tick();
    faultClr = 1'b0;
    chk(faultFlag, 1'b0, "R6 clear input drops flag");
    for (int i = 0; i < 3; i++) tick();
  endtask

  // Dominant run of n samples; clrAt = edge where faultClr is high (0: none).
  task automatic pulse(input int n, input bit act, input int clrAt);
    bit   trip;
    logic f, expEn, expTx, bq1, bq2;
    trip = act && (n >= LIM);
    f = 1'b0;
    bq1 = busIn;
    bq2 = busIn;
    drvActive = act;
    txIn = 1'b0;
    faultClr = (clrAt == 1);
    for (int k = 1; k <= n + 5; k++) begin
      tick();
      if (k == clrAt) f = 1'b0;
      if (trip && k == LIM + 2) f = 1'b1;
      expEn = act && !(trip && k >= LIM + 2 && k < n + 3);
      expTx = expEn ? !(k >= 2 && k <= n + 1) : 1'b1;
      chk(drvEn, expEn, act ? "R3/R4/R5 driver enable" : "R7 driver enable");
      chk(txOut, expTx, "R2 gated transmit");
      chk(faultFlag, f, act ? "R3/R6 fault flag" : "R7 fault flag");
      chk(rxOut, bq2, "R9 receive path");
      if (k == n) txIn = 1'b1;
      faultClr = (k + 1 == clrAt);
      bq2 = bq1;
      nextBus();
      bq1 = busIn;
    end
    faultClr = 1'b0;
    drvActive = 1'b1;
    settle();
  endtask

  initial begin
    #9;
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(drvEn, 1'b1, "R1 driver enable after reset");
    chk(txOut, 1'b1, "R1 transmit recessive after reset");
    chk(rxOut, 1'b1, "R1 receive recessive after reset");
    chk(faultFlag, 1'b0, "R1 fault clear after reset");
    settle();

    // R3/R4 sweep across the limit
    for (int n = 1; n <= LIM + 3; n++) pulse(n, 1'b1, 0);
    // R5 long hold: saturation, no wrap
    pulse(3 * LIM, 1'b1, 0);
    // R6 set wins over clear on the trip edge
    pulse(2 * LIM, 1'b1, LIM + 2);
    // R6 clear while tripped: flag drops, driver stays off
    pulse(2 * LIM, 1'b1, LIM + 5);
    // R7 inactive mode, long dominant run
    pulse(2 * LIM, 1'b0, 0);

    // R8 dominant held across entry into active mode
    drvActive = 1'b0;
    txIn = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    drvActive = 1'b1;
    for (int k = 1; k <= 2 * LIM + 4; k++) begin
      tick();
      chk(drvEn, 1'b1, "R8 no timing without fresh edge");
      chk(faultFlag, 1'b0, "R8 no fault without fresh edge");
      chk(txOut, 1'b0, "R8 dominant passes through");
    end
    settle();

    // R10 drop active mode mid-run, then restart timing
    drvActive = 1'b1;
    txIn = 1'b0;
    for (int k = 1; k <= 2 * LIM + 4; k++) begin
      tick();
      chk(drvEn, (k == LIM - 1) ? 1'b0 : 1'b1, "R10 abandoned run");
      chk(faultFlag, 1'b0, "R10 abandoned run no fault");
      if (k == LIM - 2) drvActive = 1'b0;
      if (k == LIM - 1) drvActive = 1'b1;
    end
    settle();
    pulse(LIM - 1, 1'b1, 0);  // R10 fresh run just under limit
    pulse(LIM, 1'b1, 0);      // R10 fresh run at limit trips

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule